// File: doc/BRIEF.md
# Raster Timing Event Generator

This block walks a progressive video raster from programmable horizontal and vertical timing values and produces the events that display control logic needs. It keeps a horizontal and vertical position and a running pixel-in-frame count. It also keeps a scanline count that steps at the leading edge of horizontal sync, and a 24-bit frame count. It emits single-cycle strobes for start of vertical blank, frame start and start of vertical sync, plus a latch strobe that copies the pending timing configuration into the working copy. A small register read port returns coherent snapshots of the counters.

The raster origin (position 0,0) is the first pixel of the first active line. Active pixels are horizontal positions below the horizontal blank start, and active lines are vertical lines below the vertical blank start. Every output is registered. A strobe or level caused by the raster standing at position (h,v) is therefore visible in the clock cycle after the one in which the counters hold (h,v).

Top module: `raster_event_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, the strobes, hsync, vsync, display enable, pixel count, frame count and read data are all zero, and the scanline count reads vtotal-1. The timing inputs are loaded into the working configuration during reset.
- R2: The start-of-vblank strobe and the latch strobe both pulse for exactly one cycle, in the cycle after the raster stands at the hsync-start position on line vblank_start-1. They never coincide with the frame-start or vsync-start strobe.
- R3: Changes on the timing inputs have no effect on the raster until the edge that raises the latch strobe. From that edge on, all event decoding and counter wrapping use the new values.
- R4: The scanline count takes the true line index at the hsync-start position of each line. Before that point on the line it keeps the previous line's index, so on line 0 it reads vtotal-1.
- R5: The frame-start strobe pulses in the cycle after the raster stands at the horizontal blank start on line vblank_start+D. D is the 2-bit delay input, so frame start falls 1 to 4 lines after start of vblank, and never while display enable is high.
- R6: The vsync-start strobe pulses after the hsync-start position on line vsync_start-1. The vsync level rises with it and falls after the hsync-start position on line vsync_end-1.
- R7: The pixel count is zero at the raster origin, increments every cycle and returns to zero after the last position of the frame.
- R8: The frame count increments by one, modulo 2^24, at each start-of-vblank strobe and holds otherwise.
- R9: A read request returns data in the next cycle, captured from all counters on the same edge. Address 0 gives {frame[7:0], pixel[23:0]}. Address 1 gives the frame count, address 2 gives the scanline count, both zero-extended, and address 3 gives zero. Read data holds between requests.
- R10: hsync is high for horizontal positions from hsync start up to but not including hsync end. Display enable is high for positions below both blank starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one pixel per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cfg_htotal | input | 12 | Pixels per line (pending) |
| cfg_hblank | input | 12 | First horizontal blank position |
| cfg_hsync_on | input | 12 | First hsync position |
| cfg_hsync_off | input | 12 | First position after hsync |
| cfg_vtotal | input | 12 | Lines per frame |
| cfg_vblank | input | 12 | First blank line |
| cfg_vsync_on | input | 12 | First vsync line |
| cfg_vsync_off | input | 12 | First line after vsync |
| cfg_fs_delay | input | 2 | Extra lines before frame start |
| rd_en | input | 1 | Read request |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, one cycle after request |
| sob_o | output | 1 | Start-of-vblank strobe |
| latch_o | output | 1 | Configuration latch strobe |
| fstart_o | output | 1 | Frame-start strobe |
| vs_start_o | output | 1 | Vsync-start strobe |
| hsync_o | output | 1 | Horizontal sync level |
| vsync_o | output | 1 | Vertical sync level |
| de_o | output | 1 | Display enable |
| scanline_o | output | 12 | Scanline count |
| pixel_o | output | 24 | Pixel-in-frame count |
| frame_o | output | 24 | Frame count |

## Verification
A read can land on the same edge as the start of vblank, which is also the edge on which the frame count steps and the configuration swaps. The bench walks its own reference raster and issues reads exactly in the cycles that its model predicts as start-of-vblank positions. It expects the packed word and the frame word to carry the pre-increment frame count alongside the matching pixel count. The same walk changes the timing inputs in mid-frame and checks that every strobe keeps the old positions until the latch edge and follows the new positions after it.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int RD_W = 32;

    typedef struct packed {
        logic sob;
        logic latch;
        logic fstart;
        logic vs_start;
    } rg_evt_t;

    typedef enum logic [1:0] {
        RA_PACKED = 2'd0,
        RA_FRAME  = 2'd1,
        RA_LINE   = 2'd2,
        RA_NONE   = 2'd3
    } rg_addr_e;

endpackage

// File: rtl/rtg_shadow.sv
module rtg_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || load) q <= d;
    end
endmodule

// File: rtl/rtg_position.sv
module rtg_position #(
    parameter int HW = 12,
    parameter int VW = 12,
    parameter int PW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] htotal,
    input  logic [VW-1:0] vtotal,
    output logic [HW-1:0] h,
    output logic [VW-1:0] v,
    output logic [PW-1:0] pix
);
    localparam logic [HW-1:0] ONE_H = HW'(1);
    localparam logic [VW-1:0] ONE_V = VW'(1);

    logic eol, eof;
    assign eol = (h == htotal - ONE_H);
    assign eof = eol && (v == vtotal - ONE_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            h   <= '0;
            v   <= '0;
            pix <= '0;
        end else begin
            h   <= eol ? '0 : h + ONE_H;
            if (eol) v <= eof ? '0 : v + ONE_V;
            pix <= eof ? '0 : pix + PW'(1);
        end
    end
endmodule

// File: rtl/rtg_events.sv
module rtg_events
    import raster_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 12,
    parameter int FW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] h,
    input  logic [VW-1:0] v,
    input  logic [HW-1:0] hblank,
    input  logic [HW-1:0] hsync_on,
    input  logic [HW-1:0] hsync_off,
    input  logic [VW-1:0] vtotal,
    input  logic [VW-1:0] vblank,
    input  logic [VW-1:0] vsync_on,
    input  logic [VW-1:0] vsync_off,
    input  logic [1:0]    fs_delay,
    output logic          sob_now,
    output rg_evt_t       evt,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [VW-1:0] scan,
    output logic [FW-1:0] frame
);
    localparam logic [VW-1:0] ONE_V = VW'(1);

    logic at_hs, at_sob, at_fs, at_vs_on, at_vs_off;
    logic [VW-1:0] fs_line;

    assign fs_line   = vblank + VW'(fs_delay);
    assign at_hs     = (h == hsync_on);
    assign at_sob    = at_hs && (v == vblank - ONE_V);
    assign at_vs_on  = at_hs && (v == vsync_on - ONE_V);
    assign at_vs_off = at_hs && (v == vsync_off - ONE_V);
    assign at_fs     = (h == hblank) && (v == fs_line);
    assign sob_now   = at_sob;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt   <= '0;
            hsync <= 1'b0;
            vsync <= 1'b0;
            de    <= 1'b0;
            scan  <= vtotal - ONE_V;
            frame <= '0;
        end else begin
            evt.sob      <= at_sob;
            evt.latch    <= at_sob;
            evt.fstart   <= at_fs;
            evt.vs_start <= at_vs_on;
            hsync        <= (h >= hsync_on) && (h < hsync_off);
            de           <= (h < hblank) && (v < vblank);
            if (at_vs_on)       vsync <= 1'b1;
            else if (at_vs_off) vsync <= 1'b0;
            if (at_hs)  scan  <= v;
            if (at_sob) frame <= frame + FW'(1);
        end
    end
endmodule

// File: rtl/raster_event_gen.sv
module raster_event_gen
    import raster_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 12,
    parameter int PW = 24,
    parameter int FW = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [HW-1:0]   cfg_htotal,
    input  logic [HW-1:0]   cfg_hblank,
    input  logic [HW-1:0]   cfg_hsync_on,
    input  logic [HW-1:0]   cfg_hsync_off,
    input  logic [VW-1:0]   cfg_vtotal,
    input  logic [VW-1:0]   cfg_vblank,
    input  logic [VW-1:0]   cfg_vsync_on,
    input  logic [VW-1:0]   cfg_vsync_off,
    input  logic [1:0]      cfg_fs_delay,
    input  logic            rd_en,
    input  logic [1:0]      rd_addr,
    output logic [RD_W-1:0] rd_data,
    output logic            sob_o,
    output logic            latch_o,
    output logic            fstart_o,
    output logic            vs_start_o,
    output logic            hsync_o,
    output logic            vsync_o,
    output logic            de_o,
    output logic [VW-1:0]   scanline_o,
    output logic [PW-1:0]   pixel_o,
    output logic [FW-1:0]   frame_o
);
    localparam int CFG_W  = 4 * HW + 4 * VW + 2;
    localparam int FRM_LO = RD_W - PW;

    logic [CFG_W-1:0] pend_bus, act_bus;
    logic [HW-1:0] a_ht, a_hb, a_hson, a_hsoff;
    logic [VW-1:0] a_vt, a_vb, a_vson, a_vsoff;
    logic [1:0]    a_fsd;
    logic          sob_now;
    logic [HW-1:0] h;
    logic [VW-1:0] v;
    rg_evt_t       evt;

    assign pend_bus = {cfg_htotal, cfg_hblank, cfg_hsync_on, cfg_hsync_off,
                       cfg_vtotal, cfg_vblank, cfg_vsync_on, cfg_vsync_off,
                       cfg_fs_delay};
    assign {a_ht, a_hb, a_hson, a_hsoff, a_vt, a_vb, a_vson, a_vsoff, a_fsd} = act_bus;

    rtg_shadow #(.W(CFG_W)) shadow_i (
        .clk(clk), .rst(rst), .load(sob_now), .d(pend_bus), .q(act_bus)
    );

    rtg_position #(.HW(HW), .VW(VW), .PW(PW)) pos_i (
        .clk(clk), .rst(rst), .htotal(a_ht), .vtotal(a_vt),
        .h(h), .v(v), .pix(pixel_o)
    );

    rtg_events #(.HW(HW), .VW(VW), .FW(FW)) evt_i (
        .clk(clk), .rst(rst), .h(h), .v(v),
        .hblank(a_hb), .hsync_on(a_hson), .hsync_off(a_hsoff),
        .vtotal(a_vt), .vblank(a_vb), .vsync_on(a_vson), .vsync_off(a_vsoff),
        .fs_delay(a_fsd), .sob_now(sob_now), .evt(evt),
        .hsync(hsync_o), .vsync(vsync_o), .de(de_o),
        .scan(scanline_o), .frame(frame_o)
    );

    assign sob_o      = evt.sob;
    assign latch_o    = evt.latch;
    assign fstart_o   = evt.fstart;
    assign vs_start_o = evt.vs_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (rg_addr_e'(rd_addr))
                RA_PACKED: rd_data <= {frame_o[FRM_LO-1:0], pixel_o};
                RA_FRAME:  rd_data <= RD_W'(frame_o);
                RA_LINE:   rd_data <= RD_W'(scanline_o);
                default:   rd_data <= '0;
            endcase
        end
    end
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
    parameter int FW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic          sob,
    input logic          fstart,
    input logic          vs_start,
    input logic          vsync,
    input logic          de,
    input logic [FW-1:0] frame
);
    AST_SOB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sob |=> !sob); // R2

    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sob, fstart, vs_start})); // R2

    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (rst)
        sob |-> (frame == $past(frame) + FW'(1))); // R8

    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sob |-> $stable(frame)); // R8

    AST_VSYNC_RISE: assert property (@(posedge clk) disable iff (rst)
        vs_start |-> (vsync && !$past(vsync))); // R6

    AST_FSTART_BLANK: assert property (@(posedge clk) disable iff (rst)
        fstart |-> !de); // R5
endmodule

bind raster_event_gen rtg_checker #(.FW(FW)) chk_i (
    .clk(clk), .rst(rst), .sob(sob_o), .fstart(fstart_o),
    .vs_start(vs_start_o), .vsync(vsync_o), .de(de_o), .frame(frame_o)
);

// File: tb/raster_event_gen_tb.sv
`timescale 1ns/1ps
module raster_event_gen_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [11:0] c_ht, c_hb, c_hson, c_hsoff, c_vt, c_vb, c_vson, c_vsoff;
    logic [1:0]  c_fsd;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic sob_o, latch_o, fstart_o, vs_start_o, hsync_o, vsync_o, de_o;
    logic [11:0] scanline_o;
    logic [23:0] pixel_o, frame_o;

    int n_chk = 0, n_err = 0;
    bit done = 0;
    // reference raster state
    int mh, mv, mpix, mfrm, mscan, mvs, nsob;
    int m_ht, m_hb, m_hson, m_hsoff, m_vt, m_vb, m_vson, m_vsoff, m_fsd;

    always #2.5 clk = ~clk;

    raster_event_gen dut_i (
        .clk(clk), .rst(rst),
        .cfg_htotal(c_ht), .cfg_hblank(c_hb), .cfg_hsync_on(c_hson), .cfg_hsync_off(c_hsoff),
        .cfg_vtotal(c_vt), .cfg_vblank(c_vb), .cfg_vsync_on(c_vson), .cfg_vsync_off(c_vsoff),
        .cfg_fs_delay(c_fsd), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .sob_o(sob_o), .latch_o(latch_o), .fstart_o(fstart_o), .vs_start_o(vs_start_o),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .scanline_o(scanline_o), .pixel_o(pixel_o), .frame_o(frame_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic load_model_cfg();
        m_ht = c_ht; m_hb = c_hb; m_hson = c_hson; m_hsoff = c_hsoff;
        m_vt = c_vt; m_vb = c_vb; m_vson = c_vson; m_vsoff = c_vsoff; m_fsd = c_fsd;
    endtask

    task automatic set_cfg(input int ht, hb, hson, hsoff, vt, vb, vson, vsoff, fsd);
        c_ht = 12'(ht); c_hb = 12'(hb); c_hson = 12'(hson); c_hsoff = 12'(hsoff);
        c_vt = 12'(vt); c_vb = 12'(vb); c_vson = 12'(vson); c_vsoff = 12'(vsoff);
        c_fsd = 2'(fsd);
    endtask

    function automatic bit pred_sob();
        return (mh == m_hson) && (mv == m_vb - 1);
    endfunction

    // one clock of the reference walk; called at a falling edge
    task automatic step(input bit re, input int ra);
        bit e_sob, e_fs, e_vson, e_vsoff, e_hs, e_de;
        int e_rd;
        rd_en = re; rd_addr = 2'(ra);
        e_sob   = pred_sob();
        e_fs    = (mh == m_hb) && (mv == m_vb + m_fsd);
        e_vson  = (mh == m_hson) && (mv == m_vson - 1);
        e_vsoff = (mh == m_hson) && (mv == m_vsoff - 1);
        e_hs    = (mh >= m_hson) && (mh < m_hsoff);
        e_de    = (mh < m_hb) && (mv < m_vb);
        case (ra)
            0: e_rd = ((mfrm & 255) << 24) | mpix;
            1: e_rd = mfrm;
            2: e_rd = mscan;
            default: e_rd = 0;
        endcase
        if (mh == m_hson) mscan = mv;
        if (e_sob) mfrm = (mfrm + 1) & 24'hFFFFFF;
        if (e_vson) mvs = 1; else if (e_vsoff) mvs = 0;
        mpix = (mh == m_ht - 1 && mv == m_vt - 1) ? 0 : mpix + 1;
        if (mh == m_ht - 1) begin
            mh = 0;
            mv = (mv == m_vt - 1) ? 0 : mv + 1;
        end else mh++;
        if (e_sob) begin load_model_cfg(); nsob++; end
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        chk("R2", "sob", sob_o, e_sob);
        chk("R2", "latch", latch_o, e_sob);
        chk("R5", "fstart", fstart_o, e_fs);
        chk("R6", "vs_start", vs_start_o, e_vson);
        chk("R6", "vsync", vsync_o, mvs);
        chk("R10", "hsync", hsync_o, e_hs);
        chk("R10", "de", de_o, e_de);
        chk("R7", "pixel", pixel_o, mpix);
        chk("R4", "scanline", scanline_o, mscan);
        chk("R8", "frame", frame_o, mfrm);
        if (re) chk("R9", "rd_data", rd_data, e_rd);
    endtask

    task automatic t_reset();
        set_cfg(16, 10, 12, 14, 10, 6, 7, 8, 0);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1", "sob", sob_o, 0);
        chk("R1", "fstart", fstart_o, 0);
        chk("R1", "vsync", vsync_o, 0);
        chk("R1", "de", de_o, 0);
        chk("R1", "pixel", pixel_o, 0);
        chk("R1", "frame", frame_o, 0);
        chk("R1", "rd_data", rd_data, 0);
        chk("R1", "scanline", scanline_o, 9);
        load_model_cfg();
        mh = 0; mv = 0; mpix = 0; mfrm = 0; mscan = m_vt - 1; mvs = 0; nsob = 0;
        rst = 1'b0;
    endtask

    task automatic t_frames(input int n);  // R2 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < n; i++) step(0, 0);
    endtask

    task automatic t_swap();  // R3: new timing only after the latch edge
        for (int i = 0; i < 50; i++) step(0, 0);
        set_cfg(20, 12, 15, 17, 12, 7, 9, 10, 3);
        for (int i = 0; i < 3 * 240 + 160; i++) step(0, 0);
    endtask

    task automatic t_reads();  // R9, including reads on the start-of-vblank edge
        for (int i = 0; i < 600; i++) begin
            if (pred_sob()) step(1, nsob % 3);
            else if (i % 13 == 0) step(1, i % 4);
            else step(0, 0);
        end
    endtask

    initial begin
        t_reset();
        t_frames(3 * 160);
        t_swap();
        t_reads();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule